// File: doc/BRIEF.md
# Single-Error-Tolerant Register File Decoder

This block is the row decoder and read path of a small storage array that is addressed by codeword tags, not by plain binary indices. Entry i owns one main pointer, a 7-bit single-error-correcting codeword derived from i. The row of entry i is enabled by an exact match on that pointer and also by any tag that differs from it in a single bit. A tag that was hit by an upset while it sat in a pipeline structure therefore still reaches the intended row, with no correction step in front of the decoder.

Each row ORs n+1 match terms: the exact term plus one term per single-bit variant. The exact term is resolved through a selector, so an exact hit drives the row on its own. When a row is enabled only through a variant term, a fault flag rises. A miss flag rises when no row matches, and the read data is then zero. The write port uses the same tolerant decode. An optional extra overall-parity bit widens the tag to 8 bits. Two-bit corruptions then become detectable misses, where the 7-bit code would silently choose a wrong row.

Top module: `cptr_regfile`

## Requirements
- R1: The main pointer of entry i (i = d3 d2 d1 d0) has bit 2 = d0, bit 4 = d1, bit 5 = d2, bit 6 = d3, bit 0 = d0^d1^d3, bit 1 = d0^d2^d3 and bit 3 = d1^d2^d3. When the parity option is on, bit 7 is the XOR of bits 0 to 6.
- R2: A read tag equal to the main pointer of entry i sets only bit i of `rd_sel`, returns entry i on `rd_data`, and keeps `rd_fault` and `rd_miss` low.
- R3: A read tag that differs from the main pointer of entry i in exactly one bit (any bit) sets only bit i of `rd_sel`, returns entry i and raises `rd_fault`, with `rd_miss` low.
- R4: A read tag that is at least two bits from every main pointer sets no bit of `rd_sel`, returns zero data, raises `rd_miss` and keeps `rd_fault` low.
- R5: `rd_sel` never has more than one bit set.
- R6: With `wr_en` high, the entry matched by `wr_tag` (exactly or through one flipped bit) takes `wr_data` at the rising clock edge. Read outputs follow the tag combinationally within the same cycle.
- R7: A write whose tag matches no entry changes no stored word.
- R8: After reset every entry reads as zero.
- R9: With the default 7-bit tag, every one of the 128 tag values selects exactly one entry and `rd_miss` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears all entries |
| wr_en | input | 1 | Write request |
| wr_tag | input | TAG_W | Codeword tag of the entry to write |
| wr_data | input | DATA_W | Word to store |
| rd_tag | input | TAG_W | Codeword tag of the entry to read |
| rd_data | output | DATA_W | Selected word, zero on a miss |
| rd_sel | output | N_ENTRIES | One-hot row enable of the read port |
| rd_fault | output | 1 | Row enabled through a single-bit variant |
| rd_miss | output | 1 | No row matches the read tag |

## Verification
The main instance is built with the parity option on (8-bit tags, 16 entries of 32 bits). With a minimum distance of four, a double flip lands on no codeword, so the miss path, zero read data and ignored writes become reachable. A second instance keeps the 7-bit default. For that instance the bench sweeps all 128 tags to show that the perfect code leaves no tag unmatched and that every tag enables exactly one row. In both builds, writes are also issued through corrupted tags so that the write decoder's tolerance is checked at the ports.

// File: rtl/cptr_pkg.sv
package cptr_pkg;

  // Main pointer of entry d: single-error-correcting codeword, optional
  // overall parity in bit 7 (zero when the option is off).
  function automatic logic [7:0] main_ptr(input logic [3:0] d, input bit ext);
    logic [7:0] c;
    c[0] = d[0] ^ d[1] ^ d[3];
    c[1] = d[0] ^ d[2] ^ d[3];
    c[2] = d[0];
    c[3] = d[1] ^ d[2] ^ d[3];
    c[4] = d[1];
    c[5] = d[2];
    c[6] = d[3];
    c[7] = ext ? ^c[6:0] : 1'b0;
    return c;
  endfunction

endpackage

// File: rtl/cptr_row_match.sv
module cptr_row_match #(
  parameter int TAG_W = 7
) (
  input  logic [TAG_W-1:0] tag,
  input  logic [TAG_W-1:0] ptr,
  output logic             row_sel,
  output logic             row_near
);
  localparam logic [TAG_W-1:0] ONE = TAG_W'(1);

  logic             exact_hit;
  logic [TAG_W-1:0] flip_hit;
  logic             near_any;

  assign exact_hit = (tag == ptr);

  for (genvar b = 0; b < TAG_W; b++) begin : g_flip
    assign flip_hit[b] = ((tag ^ ptr) == (ONE << b));
  end

  assign near_any = |flip_hit;
  // exact term wins through the selector; variants only matter otherwise
  assign row_sel  = exact_hit ? 1'b1 : near_any;
  assign row_near = near_any & ~exact_hit;
endmodule

// File: rtl/cptr_read_or.sv
module cptr_read_or #(
  parameter int N = 16,
  parameter int W = 32
) (
  input  logic [N-1:0]   sel,
  input  logic [N*W-1:0] words,
  output logic [W-1:0]   data
);
  always_comb begin
    data = '0;
    for (int i = 0; i < N; i++)
      if (sel[i]) data = data | words[i*W +: W];
  end
endmodule

// File: rtl/cptr_regfile.sv
module cptr_regfile #(
  parameter int N_ENTRIES  = 16,
  parameter int DATA_W     = 32,
  parameter bit EXT_PARITY = 1'b0,
  localparam int TAG_W     = 7 + (EXT_PARITY ? 1 : 0)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [TAG_W-1:0]     wr_tag,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [TAG_W-1:0]     rd_tag,
  output logic [DATA_W-1:0]    rd_data,
  output logic [N_ENTRIES-1:0] rd_sel,
  output logic                 rd_fault,
  output logic                 rd_miss
);
  import cptr_pkg::*;

  logic [N_ENTRIES*DATA_W-1:0] mem_flat;
  logic [N_ENTRIES-1:0]        rd_near;
  logic [N_ENTRIES-1:0]        wr_sel;
  logic [N_ENTRIES-1:0]        wr_near;
  logic                        wr_miss;

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_entry
    localparam logic [7:0] FULL = main_ptr(4'(e), EXT_PARITY);
    localparam logic [TAG_W-1:0] PTR = FULL[TAG_W-1:0];

    cptr_row_match #(.TAG_W(TAG_W)) u_rd_match (
      .tag(rd_tag), .ptr(PTR), .row_sel(rd_sel[e]), .row_near(rd_near[e]));

    cptr_row_match #(.TAG_W(TAG_W)) u_wr_match (
      .tag(wr_tag), .ptr(PTR), .row_sel(wr_sel[e]), .row_near(wr_near[e]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 mem_flat[e*DATA_W +: DATA_W] <= '0;
      else if (wr_en && wr_sel[e]) mem_flat[e*DATA_W +: DATA_W] <= wr_data;
    end
  end

  cptr_read_or #(.N(N_ENTRIES), .W(DATA_W)) u_read (
    .sel(rd_sel), .words(mem_flat), .data(rd_data));

  assign rd_miss  = ~|rd_sel;
  assign rd_fault = |rd_near;
  assign wr_miss  = ~|wr_sel;

  // R5: at most one row enabled
  p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_sel));
  // R4: a miss reads as zero
  p_miss_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_miss |-> (rd_data == '0));
  // R3: a fault flag always comes with a selected row
  p_fault_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fault |-> ($countones(rd_sel) == 1));
  // R6: a write to the row being read shows up after the edge
  p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_miss && (wr_sel == rd_sel)) |=>
      ($stable(rd_sel) |-> (rd_data == $past(wr_data))));
  // R7: an unmatched write leaves the read word unchanged
  p_miss_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_miss) |=> ($stable(rd_tag) |-> $stable(rd_data)));
  // R3: the write decoder tolerates a flip, so a write never matches two rows
  p_wr_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($onehot0(wr_sel) && ($countones(wr_near) <= 1)));
endmodule

// File: tb/cptr_regfile_bench.sv
module cptr_regfile_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;

  // 8-bit build
  logic        wr_en = 1'b0;
  logic [7:0]  wr_tag = '0, rd_tag = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [15:0] rd_sel;
  logic        rd_fault, rd_miss;

  cptr_regfile #(.N_ENTRIES(16), .DATA_W(32), .EXT_PARITY(1'b1)) u_cptr_regfile (
    .clk, .rst_n, .wr_en, .wr_tag, .wr_data, .rd_tag,
    .rd_data, .rd_sel, .rd_fault, .rd_miss);

  // 7-bit default build
  logic        s_wr_en = 1'b0;
  logic [6:0]  s_wr_tag = '0, s_rd_tag = '0;
  logic [31:0] s_wr_data = '0, s_rd_data;
  logic [15:0] s_rd_sel;
  logic        s_rd_fault, s_rd_miss;

  cptr_regfile u_cptr_regfile_7b (
    .clk, .rst_n, .wr_en(s_wr_en), .wr_tag(s_wr_tag), .wr_data(s_wr_data),
    .rd_tag(s_rd_tag), .rd_data(s_rd_data), .rd_sel(s_rd_sel),
    .rd_fault(s_rd_fault), .rd_miss(s_rd_miss));

  // R1 restated as generator rows (with parity bit) XORed per data bit
  function automatic logic [7:0] enc(input int i);
    logic [7:0] rows [4];
    logic [7:0] c = '0;
    rows[0] = 8'h87; rows[1] = 8'h99; rows[2] = 8'hAA; rows[3] = 8'h4B;
    for (int k = 0; k < 4; k++) if (i[k]) c ^= rows[k];
    return c;
  endfunction

  function automatic logic [31:0] pat(input int i);
    return 32'h5EED_0000 + 32'(i) * 32'h0101_0111;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write8(input logic [7:0] t, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_tag = t; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // kind: 0 exact, 1 single flip, 2 uncorrectable
  typedef struct packed { logic [3:0] idx; logic [7:0] flip; logic [1:0] kind; } vec_t;
  localparam vec_t VECS [14] = '{
    '{4'd0,  8'h00, 2'd0}, '{4'd5,  8'h00, 2'd0}, '{4'd15, 8'h00, 2'd0},
    '{4'd3,  8'h01, 2'd1}, '{4'd9,  8'h04, 2'd1}, '{4'd12, 8'h40, 2'd1},
    '{4'd7,  8'h80, 2'd1}, '{4'd10, 8'h08, 2'd1}, '{4'd1,  8'h20, 2'd1},
    '{4'd0,  8'h03, 2'd2}, '{4'd6,  8'h81, 2'd2}, '{4'd11, 8'h50, 2'd2},
    '{4'd14, 8'h0C, 2'd2}, '{4'd2,  8'hC0, 2'd2}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state
    for (int i = 0; i < 16; i++) begin
      rd_tag = enc(i); #1;
      check("R8 reset", 64'(rd_data), 64'd0);
    end
    // R6: fill, odd entries through a corrupted tag
    for (int i = 0; i < 16; i++)
      write8(enc(i) ^ ((i % 2) ? (8'h01 << (i % 8)) : 8'h00), pat(i));
    // R6: combinational read, same-cycle tag change
    rd_tag = enc(4); #1;
    check("R6 read", 64'(rd_data), 64'(pat(4)));
    rd_tag = enc(13); #1;
    check("R6 read", 64'(rd_data), 64'(pat(13)));
    // table walk: R2, R3, R4, R5
    foreach (VECS[v]) begin
      @(negedge clk);
      rd_tag = enc(VECS[v].idx) ^ VECS[v].flip; #1;
      if (VECS[v].kind == 2'd2) begin
        check("R4 sel",   64'(rd_sel),   64'd0);
        check("R4 data",  64'(rd_data),  64'd0);
        check("R4 miss",  64'(rd_miss),  64'd1);
        check("R4 fault", 64'(rd_fault), 64'd0);
      end else begin
        check(VECS[v].kind == 2'd0 ? "R2 sel" : "R3 sel", 64'(rd_sel),
              64'(16'h1 << VECS[v].idx));
        check(VECS[v].kind == 2'd0 ? "R2 data" : "R3 data", 64'(rd_data),
              64'(pat(VECS[v].idx)));
        check(VECS[v].kind == 2'd0 ? "R2 fault" : "R3 fault", 64'(rd_fault),
              64'(VECS[v].kind == 2'd1));
        check("R5 miss", 64'(rd_miss), 64'd0);
      end
    end
    // R3: every single flip of entry 8 on the read side
    for (int b = 0; b < 8; b++) begin
      rd_tag = enc(8) ^ (8'h01 << b); #1;
      check("R3 flip", {32'(rd_sel), rd_data}, {32'(16'h0100), pat(8)});
    end
    // R7: uncorrectable write tags touch nothing
    write8(enc(6) ^ 8'h11, 32'hDEAD_BEEF);
    write8(enc(9) ^ 8'h82, 32'hDEAD_BEEF);
    for (int i = 0; i < 16; i++) begin
      rd_tag = enc(i); #1;
      check("R7 kept", 64'(rd_data), 64'(pat(i)));
    end
    // R6: overwrite through a parity-bit flip
    write8(enc(2) ^ 8'h80, 32'h1234_5678);
    rd_tag = enc(2); #1;
    check("R6 overwrite", 64'(rd_data), 64'h1234_5678);
    // R1: main pointers of the 7-bit build, written then read exactly
    @(negedge clk); s_wr_en = 1'b1; s_wr_tag = enc(11) ^ 7'h10; s_wr_data = 32'hCAFE_0011;
    @(negedge clk); s_wr_en = 1'b0;
    s_rd_tag = enc(11); #1;
    check("R1 code", {32'(s_rd_sel), s_rd_data, 31'd0, s_rd_fault},
          {32'(16'h0800), 32'hCAFE_0011, 32'd0});
    // R9: perfect 7-bit code, full sweep
    for (int t = 0; t < 128; t++) begin
      s_rd_tag = 7'(t); #1;
      check("R9 onehot", 64'($countones(s_rd_sel)), 64'd1);
      check("R9 miss", 64'(s_rd_miss), 64'd0);
    end
    // R8: reset again clears stored words
    rst_n = 1'b0; #1; rst_n = 1'b1;
    rd_tag = enc(2); #1;
    check("R8 re-reset", 64'(rd_data), 64'd0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule